// File: doc/BRIEF.md
# Tagged Two-Bit Branch Predictor with Static Fallback

This block predicts conditional branches at fetch time. Fetch presents the address of a branch and a flag telling whether its offset points backward. In the same cycle the block answers with a direction and, when it holds a record of that branch, the target it last saw. The records sit in a direct-indexed table. Each slot keeps a valid flag, the upper address bits as a tag, a two-bit saturating confidence state and a target address. When the tag does not match, a fixed rule answers instead: loops, meaning backward branches, are guessed taken and forward branches are guessed not taken.

The table learns only from a separate retirement port. That port carries the branch address, the resolved direction and the resolved target. A retiring branch that matches its slot moves the state one step toward the outcome. A branch that does not match claims the slot, replacing whatever was there. Lookups are purely combinational reads of the registered table, so a retirement write becomes visible on the cycle after it is presented.

Top module: `bpred_hybrid`

## Requirements
- R1: After reset every slot is invalid, so every lookup reports `pred_hit` = 0 until the first retirement.
- R2: When the lookup misses, `pred_taken` equals `lk_backward`, `pred_target` is zero and `pred_hit` is 0.
- R3: A slot matches when it is valid and its stored tag equals `lk_pc[31:8]`. On a match `pred_hit` is 1 and `pred_taken` is 1 exactly when the state is weakly or strongly taken (state codes 2 and 3).
- R4: On a match `pred_target` equals the target stored in that slot.
- R5: A retirement that misses its slot allocates it. The slot gets the retiring tag and target, and a state of weakly taken (2) for a taken outcome or weakly not-taken (1) otherwise. Any previous occupant of that slot is discarded.
- R6: A retirement that matches moves the state one step toward the outcome: taken counts up, not-taken counts down, and the state saturates at strongly not-taken (0) and strongly taken (3). From a strong state the direction flips only after two opposing outcomes.
- R7: A matching retirement with a taken outcome replaces the stored target. A not-taken outcome keeps the stored target.
- R8: A lookup and a retirement in the same cycle see the table as it was before that retirement. The write shows on the next cycle.
- R9: Lookups never change the table. Repeated lookups of one address give the same answer until a retirement touches its slot.
- R10: The slot index is `pc[7:2]` for both ports, and address bits [1:0] are ignored. Two addresses that share bits [7:2] but differ above them compete for one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Address of the branch being fetched |
| lk_backward | input | 1 | Branch offset is negative |
| pred_hit | output | 1 | A matching slot supplied the prediction |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_target | output | 32 | Predicted target, zero on a miss |
| up_valid | input | 1 | A branch retires this cycle |
| up_pc | input | 32 | Address of the retiring branch |
| up_taken | input | 1 | Resolved direction of the retiring branch |
| up_target | input | 32 | Resolved target of the retiring branch |

## Verification
The hardest case to reach is a lookup and a retirement meeting on one slot in the same cycle, particularly when the retirement evicts a different tag. The stimulus drives these deliberately: it retires an address while fetching that address or an alias that shares its index. A random phase then draws addresses from a small pool of aliasing pairs, so evictions and same-slot collisions happen often. A behavioural model keyed by slot index predicts every output on every cycle.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    // One saturating step toward the resolved direction
    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_ST) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    // State given to a freshly claimed slot
    function automatic ctr_e ctr_alloc(input logic taken);
        return taken ? CTR_WT : CTR_WNT;
    endfunction

    function automatic logic ctr_says_taken(input ctr_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bpred_table.sv
module bpred_table
    import bpred_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = ADDR_W - 2 - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    // fetch-side read port
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output ctr_e              rd_ctr,
    output logic [ADDR_W-1:0] rd_target,
    // retire-side read port
    input  logic [IDX_W-1:0]  rr_idx,
    output logic              rr_valid,
    output logic [TAG_W-1:0]  rr_tag,
    output ctr_e              rr_ctr,
    output logic [ADDR_W-1:0] rr_target,
    // write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  ctr_e              wr_ctr,
    input  logic [ADDR_W-1:0] wr_target
);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][1:0]        ctr;
        logic [ENTRIES-1:0][ADDR_W-1:0] target;
    } tbl_t;

    tbl_t               tbl_d, tbl_q;
    logic [ENTRIES-1:0] slot_we;

    // per-slot write decode
    for (genvar g = 0; g < ENTRIES; g++) begin : g_dec
        assign slot_we[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (slot_we[i]) begin
                tbl_d.valid[i]  = 1'b1;
                tbl_d.tag[i]    = wr_tag;
                tbl_d.ctr[i]    = wr_ctr;
                tbl_d.target[i] = wr_target;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // reads come from registered state: a same-cycle write is not seen
    always_comb begin
        rd_valid  = tbl_q.valid[rd_idx];
        rd_tag    = tbl_q.tag[rd_idx];
        rd_ctr    = ctr_e'(tbl_q.ctr[rd_idx]);
        rd_target = tbl_q.target[rd_idx];
        rr_valid  = tbl_q.valid[rr_idx];
        rr_tag    = tbl_q.tag[rr_idx];
        rr_ctr    = ctr_e'(tbl_q.ctr[rr_idx]);
        rr_target = tbl_q.target[rr_idx];
    end

endmodule

// File: rtl/bpred_lookup.sv
module bpred_lookup
    import bpred_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = ADDR_W - 2 - IDX_W
) (
    input  logic [ADDR_W-3:0] word_addr,
    input  logic              backward,
    output logic [IDX_W-1:0]  idx,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  ctr_e              ent_ctr,
    input  logic [ADDR_W-1:0] ent_target,
    output logic              hit,
    output logic              taken,
    output logic [ADDR_W-1:0] target
);

    logic [TAG_W-1:0] want_tag;

    always_comb begin
        idx      = word_addr[IDX_W-1:0];
        want_tag = word_addr[ADDR_W-3:IDX_W];
        hit      = ent_valid && (ent_tag == want_tag);
        if (hit) begin
            taken  = ctr_says_taken(ent_ctr);
            target = ent_target;
        end else begin
            // static rule: loops back taken, forward not taken
            taken  = backward;
            target = '0;
        end
    end

endmodule

// File: rtl/bpred_update.sv
module bpred_update
    import bpred_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = ADDR_W - 2 - IDX_W
) (
    input  logic              up_valid,
    input  logic [ADDR_W-3:0] word_addr,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target,
    output logic [IDX_W-1:0]  idx,
    input  logic              old_valid,
    input  logic [TAG_W-1:0]  old_tag,
    input  ctr_e              old_ctr,
    input  logic [ADDR_W-1:0] old_target,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output ctr_e              wr_ctr,
    output logic [ADDR_W-1:0] wr_target
);

    logic match;

    always_comb begin
        idx    = word_addr[IDX_W-1:0];
        wr_tag = word_addr[ADDR_W-3:IDX_W];
        match  = old_valid && (old_tag == wr_tag);
        wr_en  = up_valid;
        if (match) begin
            wr_ctr    = ctr_step(old_ctr, up_taken);
            wr_target = up_taken ? up_target : old_target;
        end else begin
            wr_ctr    = ctr_alloc(up_taken);
            wr_target = up_target;
        end
    end

endmodule

// File: rtl/bpred_hybrid.sv
module bpred_hybrid
    import bpred_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic              lk_backward,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - 2 - IDX_W;

    logic [IDX_W-1:0]  lk_idx, rr_idx, wr_idx;
    logic              rd_valid, rr_valid, wr_en;
    logic [TAG_W-1:0]  rd_tag, rr_tag, wr_tag;
    ctr_e              rd_ctr, rr_ctr, wr_ctr;
    logic [ADDR_W-1:0] rd_target, rr_target, wr_target;
    logic [3:0]        unused_lowbits;

    assign unused_lowbits = {lk_pc[1:0], up_pc[1:0]};
    assign wr_idx         = rr_idx;

    bpred_lookup #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_lookup (
        .word_addr  (lk_pc[ADDR_W-1:2]),
        .backward   (lk_backward),
        .idx        (lk_idx),
        .ent_valid  (rd_valid),
        .ent_tag    (rd_tag),
        .ent_ctr    (rd_ctr),
        .ent_target (rd_target),
        .hit        (pred_hit),
        .taken      (pred_taken),
        .target     (pred_target)
    );

    bpred_update #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_update (
        .up_valid   (up_valid),
        .word_addr  (up_pc[ADDR_W-1:2]),
        .up_taken   (up_taken),
        .up_target  (up_target),
        .idx        (rr_idx),
        .old_valid  (rr_valid),
        .old_tag    (rr_tag),
        .old_ctr    (rr_ctr),
        .old_target (rr_target),
        .wr_en      (wr_en),
        .wr_tag     (wr_tag),
        .wr_ctr     (wr_ctr),
        .wr_target  (wr_target)
    );

    bpred_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_ctr    (rd_ctr),
        .rd_target (rd_target),
        .rr_idx    (rr_idx),
        .rr_valid  (rr_valid),
        .rr_tag    (rr_tag),
        .rr_ctr    (rr_ctr),
        .rr_target (rr_target),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_ctr    (wr_ctr),
        .wr_target (wr_target)
    );

endmodule

// File: rtl/bpred_checker.sv
module bpred_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lk_pc,
    input logic              lk_backward,
    input logic              pred_hit,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_target,
    input logic              up_valid,
    input logic [ADDR_W-1:0] up_pc,
    input logic              up_taken,
    input logic [ADDR_W-1:0] up_target
);

    logic              seen_q;
    logic              pv_q, pt_q;
    logic [ADDR_W-1:0] ppc_q, ptgt_q;
    logic              same_as_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            pv_q   <= 1'b0;
            pt_q   <= 1'b0;
            ppc_q  <= '0;
            ptgt_q <= '0;
        end else begin
            seen_q <= seen_q | up_valid;
            pv_q   <= up_valid;
            pt_q   <= up_taken;
            ppc_q  <= up_pc;
            ptgt_q <= up_target;
        end
    end

    assign same_as_prev = pv_q && (lk_pc[ADDR_W-1:2] == ppc_q[ADDR_W-1:2]);

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !pred_hit);  // R1
    AST_MISS_STATIC_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (pred_taken == lk_backward));  // R2
    AST_MISS_ZERO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (pred_target == '0));  // R2
    AST_RETIRED_NOW_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        same_as_prev |-> pred_hit);  // R5
    AST_TAKEN_TARGET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (same_as_prev && pt_q) |-> (pred_target == ptgt_q));  // R7

endmodule

bind bpred_hybrid bpred_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_pc       (lk_pc),
    .lk_backward (lk_backward),
    .pred_hit    (pred_hit),
    .pred_taken  (pred_taken),
    .pred_target (pred_target),
    .up_valid    (up_valid),
    .up_pc       (up_pc),
    .up_taken    (up_taken),
    .up_target   (up_target)
);

// File: tb/tb_bpred_hybrid.sv
module tb_bpred_hybrid;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_backward = 1'b0;
    logic        pred_hit, pred_taken;
    logic [31:0] pred_target;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [31:0] up_target = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model, keyed by slot index
    int unsigned m_tag[int];
    int          m_ctr[int];
    logic [31:0] m_tgt[int];

    always #10 clk = ~clk;

    bpred_hybrid dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_backward(lk_backward),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one cycle, compare before the edge, then advance the model
    task automatic step(string req, logic [31:0] lpc, logic lb,
                        logic uv, logic [31:0] upc, logic ut, logic [31:0] utg);
        int          i;
        bit          eh;
        logic        et;
        logic [31:0] eg;
        string       r;
        @(negedge clk);
        lk_pc = lpc; lk_backward = lb;
        up_valid = uv; up_pc = upc; up_taken = ut; up_target = utg;
        #2;
        i  = int'(lpc[7:2]);
        eh = m_tag.exists(i) && (m_tag[i] == int'(lpc[31:8]));
        et = eh ? (m_ctr[i] >= 2) : lb;
        eg = eh ? m_tgt[i] : 32'h0;
        r  = (req != "") ? req : (eh ? "R3" : "R2");
        check(r, "hit", {31'b0, pred_hit}, {31'b0, eh});
        check(r, "taken", {31'b0, pred_taken}, {31'b0, et});
        check(eh && req == "" ? "R4" : r, "target", pred_target, eg);
        @(posedge clk);
        #1;
        if (uv) begin
            i = int'(upc[7:2]);
            if (m_tag.exists(i) && m_tag[i] == int'(upc[31:8])) begin
                if (ut && m_ctr[i] < 3) m_ctr[i]++;
                if (!ut && m_ctr[i] > 0) m_ctr[i]--;
                if (ut) m_tgt[i] = utg;
            end else begin
                m_tag[i] = int'(upc[31:8]);
                m_ctr[i] = ut ? 2 : 1;
                m_tgt[i] = utg;
            end
        end
    endtask

    task automatic look(string req, logic [31:0] lpc, logic lb);
        step(req, lpc, lb, 1'b0, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic retire(string req, logic [31:0] upc, logic ut, logic [31:0] utg);
        step(req, upc, 1'b0, 1'b1, upc, ut, utg);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    localparam logic [31:0] A  = 32'h0000_1040;
    localparam logic [31:0] B  = 32'h0000_1140;  // same index as A, other tag
    localparam logic [31:0] T1 = 32'h0000_2000;
    localparam logic [31:0] T2 = 32'h0000_3000;
    localparam logic [31:0] T3 = 32'h0000_4000;

    initial begin
        // R1: outputs during and after reset
        repeat (3) @(negedge clk);
        #2;
        check("R1", "hit in reset", {31'b0, pred_hit}, 32'h0);
        rst_n = 1'b1;
        look("R1", A, 1'b0);
        look("R1", 32'hFFFF_FFFC, 1'b1);
        // R2: static fallback both ways
        look("R2", A, 1'b0);
        look("R2", A, 1'b1);
        // R8: lookup of A while A retires sees the old miss
        step("R8", A, 1'b1, 1'b1, A, 1'b1, T1);
        // R5: fresh slot weakly taken, target T1
        look("R5", A, 1'b0);
        // R10: low bits ignored
        look("R10", A | 32'h3, 1'b0);
        // R9: repeated lookups unchanged
        look("R9", A, 1'b1);
        look("R9", A, 1'b0);
        // R6: hysteresis from strongly taken
        retire("R6", A, 1'b1, T1);          // ST
        retire("R6", A, 1'b0, T2);          // WT, target kept
        look("R7", A, 1'b0);                // still taken, target T1
        retire("R6", A, 1'b0, T2);          // WNT
        look("R6", A, 1'b1);                // not taken
        retire("R7", A, 1'b1, T2);          // WT, target T2
        look("R7", A, 1'b0);
        // R6: saturation at strongly not-taken
        repeat (4) retire("R6", A, 1'b0, T3);
        retire("R6", A, 1'b1, T3);          // WNT
        look("R6", A, 1'b1);
        // R10/R5: alias evicts
        look("R10", B, 1'b1);
        step("R8", A, 1'b0, 1'b1, B, 1'b0, T3);  // A still hits this cycle
        look("R5", B, 1'b1);
        look("R5", A, 1'b1);                // A evicted, static
        // random phase over an aliasing pool
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] p1, p2;
            p1 = {22'h0, 2'(($urandom % 4)), 2'b0, 4'(($urandom % 3)), 2'(($urandom % 4))};
            p2 = {22'h0, 2'(($urandom % 4)), 2'b0, 4'(($urandom % 3)), 2'(($urandom % 4))};
            step("", p1, 1'($urandom), 1'($urandom), p2, 1'($urandom), $urandom & 32'hFFFF_FFFC);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule